// File: doc/BRIEF.md
# Tagged Serial Transmitter

This block turns host writes into asynchronous serial characters. Each write puts an 8-bit value and a one-bit address/data tag into a transmit queue. A sequencer removes one item at a time and sends it on `txd`. Each frame has a low start bit, 5 to 8 data bits with the least significant bit first, an optional extra slot bit, and one or two high stop bits. The slot bit is either a parity bit (even, odd, or a fixed stick value) or, in nine-bit mode, the tag of the item. The line sits high when there is nothing to send.

Bit timing comes from a single-cycle `baud_tick` enable supplied by an external rate generator. Each bit lasts sixteen ticks. The queue holds 32 items. It can also be reduced to a single holding register. A watermark interrupt reports when the number of waiting items has fallen to a chosen fraction of the depth. A write that arrives when the queue is full is discarded and sets a sticky flag. A break request drives the line low once the character in flight has finished, and holds it low until the request is removed. Everything runs on one clock with a synchronous active-high reset.

Top module: `ser_tx_engine`

## Requirements
- R1: After reset `txd` is 1, `ovf_flag` is 0 and `tx_irq` is 1 (queue empty, level code 0).
- R2: A frame is one low start bit, then `cfg_len`+5 data bits sent least significant bit first (`cfg_len` 0..3 selects 5..8 bits, and upper bits of `wr_data` are not sent), then the optional slot bit, then stop bits at 1. Characters leave in write order.
- R3: Every bit of a frame, the start bit included, lasts exactly 16 `baud_tick` pulses. `txd` does not change during a frame except on a tick.
- R4: With `cfg_par_en`=1 and `cfg_par_stick`=0, a slot bit follows the data. `cfg_par_odd`=0 gives an even number of ones across the sent data bits plus the slot bit, and `cfg_par_odd`=1 gives an odd number.
- R5: With `cfg_par_en`=1 and `cfg_par_stick`=1, the slot bit is the constant `cfg_par_odd`, whatever the data.
- R6: With `cfg_nine`=1, the slot bit carries the `wr_tag` written with the character, whatever the parity settings. With `cfg_nine`=0, `wr_tag` has no effect on the line.
- R7: `cfg_stop2`=0 sends one stop bit and `cfg_stop2`=1 sends two.
- R8: With `cfg_fifo_en`=1, up to 32 items wait in the queue, in addition to the one being sent. A write to a full queue is dropped and sets `ovf_flag`, which then stays at 1 until reset.
- R9: With `cfg_fifo_en`=0, the queue holds at most one item. A write that arrives while that item is still waiting is dropped.
- R10: `tx_irq` is 1 exactly when the number of waiting items is no more than a threshold. The threshold is set by `cfg_lvl`: 0 gives 0, 1 gives 4, 2 gives 8, 3 gives 16, 4 gives 24 and 5 gives 28. Codes 6 and 7 give 0.
- R11: While `cfg_brk`=1, `txd` is held at 0 once the current frame has finished, and queued items are held back. When `cfg_brk` returns to 0, sending resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one item |
| wr_data | input | 8 | Character to send |
| wr_tag | input | 1 | Address/data tag sent in nine-bit mode |
| cfg_len | input | 2 | Data bits minus five |
| cfg_par_en | input | 1 | Enable the parity slot |
| cfg_par_odd | input | 1 | Odd parity, or stick value |
| cfg_par_stick | input | 1 | Send a constant slot bit |
| cfg_nine | input | 1 | Slot bit carries the tag |
| cfg_stop2 | input | 1 | Two stop bits |
| cfg_fifo_en | input | 1 | 32-deep queue when 1, one holding register when 0 |
| cfg_lvl | input | 3 | Watermark level code |
| cfg_brk | input | 1 | Break request |
| baud_tick | input | 1 | One-cycle rate enable, 16 per bit |
| txd | output | 1 | Serial line |
| tx_irq | output | 1 | Watermark interrupt |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
A write is counted in the queue at the clock edge that samples `wr_en`. `tx_irq` follows the queue count and `cfg_lvl` in the same cycle, so the bench changes the level code on a falling edge and reads the interrupt one time step later. `ovf_flag` is read at the falling edge after the dropped write. An idle sequencer takes the item one edge after the write and pulls `txd` low at that same edge. From then on, bit k of a frame stays on the line from tick 16k+1 to tick 16k+16. The monitor counts ticks from the first falling clock edge at which the start bit is seen, checks each bit at tick 16k+8, and checks the start-bit edge at ticks 16 and 17.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;

    localparam int unsigned TICKS_PER_BIT = 16;

    typedef struct packed {
        logic       tag;
        logic [7:0] data;
    } tx_item_t;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       par_stick;
        logic       nine;
        logic       stop2;
    } tx_frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_SLOT,
        ST_STOP,
        ST_BRK
    } tx_state_t;

    // Value of the bit that follows the data field
    function automatic logic slot_bit(input tx_frame_cfg_t c, input tx_item_t it);
        logic [7:0] masked;
        logic       ones;
        masked = it.data & (8'hFF >> (~c.len));
        ones   = ^masked;
        if (c.nine)
            return it.tag;
        if (c.par_stick)
            return c.par_odd;
        return c.par_odd ? ~ones : ones;
    endfunction

    // Watermark threshold as a fraction of the queue depth
    function automatic int unsigned level_thr(input logic [2:0] code, input int unsigned depth);
        case (code)
            3'd1:    return depth / 8;
            3'd2:    return depth / 4;
            3'd3:    return depth / 2;
            3'd4:    return (depth * 3) / 4;
            3'd5:    return (depth * 7) / 8;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/ser_tx_fifo.sv
module ser_tx_fifo
    import ser_tx_pkg::*;
#(
    parameter  int unsigned DEPTH = 32,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          deep_en,
    input  logic          push,
    input  tx_item_t      push_item,
    input  logic          pop,
    output tx_item_t      head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          drop
);

    tx_item_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0]   cap;
    logic            full, accept;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_wrap
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_comb begin
        cap    = deep_en ? CW'(DEPTH) : CW'(1);
        full   = (count >= cap);
        accept = push && (!full || pop);
        drop   = push && !accept;
        empty  = (count == '0);
        head   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_ptr] <= push_item;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (accept)
                wr_ptr <= wr_nxt;
            if (pop)
                rd_ptr <= rd_nxt;
            count <= count + CW'(accept) - CW'(pop);
        end
    end

endmodule

// File: rtl/ser_tx_shifter.sv
module ser_tx_shifter
    import ser_tx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          baud_tick,
    input  tx_frame_cfg_t cfg,
    input  logic          brk,
    input  logic          item_valid,
    input  tx_item_t      item,
    output logic          pop,
    output logic          txd,
    output logic          busy
);

    localparam int unsigned TW = $clog2(TICKS_PER_BIT);

    tx_state_t     state;
    tx_frame_cfg_t fcfg_q;
    logic [TW-1:0] tcnt;
    logic [2:0]    bidx;
    logic [7:0]    shreg;
    logic          slot_q;
    logic          sidx;
    logic          bit_end;
    logic          last_data;

    always_comb begin
        pop       = (state == ST_IDLE) && !brk && item_valid;
        bit_end   = baud_tick && (tcnt == TW'(TICKS_PER_BIT - 1));
        last_data = (bidx == ({1'b0, fcfg_q.len} + 3'd4));
        busy      = (state == ST_START) || (state == ST_DATA) ||
                    (state == ST_SLOT)  || (state == ST_STOP);
        case (state)
            ST_START, ST_BRK: txd = 1'b0;
            ST_DATA:          txd = shreg[0];
            ST_SLOT:          txd = slot_q;
            default:          txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            fcfg_q <= '0;
            tcnt   <= '0;
            bidx   <= '0;
            shreg  <= '0;
            slot_q <= 1'b0;
            sidx   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (brk) begin
                        state <= ST_BRK;
                    end else if (item_valid) begin
                        shreg  <= item.data;
                        slot_q <= slot_bit(cfg, item);
                        fcfg_q <= cfg;
                        tcnt   <= '0;
                        state  <= ST_START;
                    end
                end
                ST_BRK: begin
                    if (!brk)
                        state <= ST_IDLE;
                end
                default: begin
                    if (baud_tick)
                        tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) begin
                        case (state)
                            ST_START: begin
                                bidx  <= '0;
                                state <= ST_DATA;
                            end
                            ST_DATA: begin
                                shreg <= shreg >> 1;
                                if (last_data) begin
                                    sidx  <= 1'b0;
                                    state <= (fcfg_q.nine || fcfg_q.par_en) ? ST_SLOT : ST_STOP;
                                end else begin
                                    bidx <= bidx + 3'd1;
                                end
                            end
                            ST_SLOT: begin
                                sidx  <= 1'b0;
                                state <= ST_STOP;
                            end
                            default: begin
                                if (!fcfg_q.stop2 || sidx)
                                    state <= ST_IDLE;
                                else
                                    sidx <= 1'b1;
                            end
                        endcase
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/ser_tx_engine.sv
module ser_tx_engine
    import ser_tx_pkg::*;
#(
    parameter  int unsigned DEPTH = 32,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_tag,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_par_stick,
    input  logic       cfg_nine,
    input  logic       cfg_stop2,
    input  logic       cfg_fifo_en,
    input  logic [2:0] cfg_lvl,
    input  logic       cfg_brk,
    input  logic       baud_tick,
    output logic       txd,
    output logic       tx_irq,
    output logic       ovf_flag
);

    tx_item_t      wr_item, head;
    tx_frame_cfg_t frame_cfg;
    logic [CW-1:0] fifo_count, thr;
    logic          fifo_empty, fifo_drop;
    logic          sh_pop, sh_busy;
    logic          ovf_q;

    always_comb begin
        wr_item   = '{tag: wr_tag, data: wr_data};
        frame_cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                      par_stick: cfg_par_stick, nine: cfg_nine, stop2: cfg_stop2};
        thr       = CW'(level_thr(cfg_lvl, DEPTH));
        tx_irq    = (fifo_count <= thr);
        ovf_flag  = ovf_q;
    end

    ser_tx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk       (clk),
        .rst       (rst),
        .deep_en   (cfg_fifo_en),
        .push      (wr_en),
        .push_item (wr_item),
        .pop       (sh_pop),
        .head      (head),
        .count     (fifo_count),
        .empty     (fifo_empty),
        .drop      (fifo_drop)
    );

    ser_tx_shifter shifter_i (
        .clk        (clk),
        .rst        (rst),
        .baud_tick  (baud_tick),
        .cfg        (frame_cfg),
        .brk        (cfg_brk),
        .item_valid (!fifo_empty),
        .item       (head),
        .pop        (sh_pop),
        .txd        (txd),
        .busy       (sh_busy)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (fifo_drop)
            ovf_q <= 1'b1;
    end

endmodule

// File: rtl/ser_tx_checker.sv
module ser_tx_checker #(
    parameter  int unsigned DEPTH = 32,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          baud_tick,
    input logic          cfg_brk,
    input logic          cfg_fifo_en,
    input logic [2:0]    cfg_lvl,
    input logic          txd,
    input logic          tx_irq,
    input logic          ovf_flag,
    input logic [CW-1:0] count,
    input logic          busy
);

    p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !txd);

    p_bit_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> $stable(txd));

    p_depth_cap_r8: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        ovf_flag |=> ovf_flag);

    p_single_slot_r9: assert property (@(posedge clk) disable iff (rst)
        (!cfg_fifo_en && count <= CW'(1)) |=> (cfg_fifo_en || count <= CW'(1)));

    p_irq_empty_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_lvl == 3'd0) |-> (tx_irq == (count == '0)));

    p_break_low_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_brk && !busy) |=> !txd);

endmodule

bind ser_tx_engine ser_tx_checker #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .baud_tick   (baud_tick),
    .cfg_brk     (cfg_brk),
    .cfg_fifo_en (cfg_fifo_en),
    .cfg_lvl     (cfg_lvl),
    .txd         (txd),
    .tx_irq      (tx_irq),
    .ovf_flag    (ovf_flag),
    .count       (fifo_count),
    .busy        (sh_busy)
);

// File: tb/ser_tx_engine_tb_top.sv
module ser_tx_engine_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_tag = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_par_stick = 1'b0;
    logic       cfg_nine = 1'b0, cfg_stop2 = 1'b0, cfg_fifo_en = 1'b1;
    logic [2:0] cfg_lvl = 3'd0;
    logic       cfg_brk = 1'b0;
    logic       baud_tick = 1'b0;
    logic       txd, tx_irq, ovf_flag;

    int         div = 0;
    int         n_vec = 0, n_bad = 0;
    bit         mon_busy = 0, brk_ok = 0;
    string      cur_req = "R2";

    logic [15:0] q_bits [$];
    int          q_len  [$];
    int          q_slot [$];
    int          q_stop [$];
    string       q_req  [$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            div       <= 0;
            baud_tick <= 1'b0;
        end else begin
            div       <= (div == 3) ? 0 : div + 1;
            baud_tick <= (div == 3);
        end
    end

    ser_tx_engine dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_tag(wr_tag),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_par_stick(cfg_par_stick), .cfg_nine(cfg_nine), .cfg_stop2(cfg_stop2),
        .cfg_fifo_en(cfg_fifo_en), .cfg_lvl(cfg_lvl), .cfg_brk(cfg_brk),
        .baud_tick(baud_tick), .txd(txd), .tx_irq(tx_irq), .ovf_flag(ovf_flag)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: expected frame built from the requirements, then the write
    task automatic push_exp(input logic [7:0] d, input logic tag, input string req);
        logic [15:0] b;
        int n, len, sl;
        logic p;
        b = '0; n = 1; p = 1'b0; sl = -1;
        len = int'(cfg_len) + 5;
        for (int i = 0; i < len; i++) begin
            b[n] = d[i];
            p ^= d[i];
            n++;
        end
        if (cfg_nine) begin
            sl = n; b[n] = tag; n++;
        end else if (cfg_par_en) begin
            sl = n; b[n] = cfg_par_stick ? cfg_par_odd : (cfg_par_odd ? ~p : p); n++;
        end
        q_stop.push_back(n);
        b[n] = 1'b1; n++;
        if (cfg_stop2) begin
            b[n] = 1'b1; n++;
        end
        q_bits.push_back(b);
        q_len.push_back(n);
        q_slot.push_back(sl);
        q_req.push_back(req);
    endtask

    task automatic send(input logic [7:0] d, input logic tag, input string req);
        push_exp(d, tag, req);
        wr_data = d; wr_tag = tag; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_drop(input logic [7:0] d);
        wr_data = d; wr_tag = 1'b0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (q_bits.size() != 0 || mon_busy) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    // Monitor: decodes the line, pops and compares
    initial begin
        logic        prev;
        logic [15:0] b;
        int          n, t, k, sl, st;
        bit          done;
        string       rq, lbl;
        prev = 1'b1;
        @(negedge clk);
        while (rst) @(negedge clk);
        forever begin
            @(negedge clk);
            if (prev && !txd) begin
                if (q_bits.size() == 0) begin
                    if (!brk_ok)
                        check(1'b0, cur_req, "unexpected frame start", 32'd1, 32'd0);
                end else begin
                    mon_busy = 1;
                    b  = q_bits.pop_front();
                    n  = q_len.pop_front();
                    sl = q_slot.pop_front();
                    st = q_stop.pop_front();
                    rq = q_req.pop_front();
                    t = 0; done = 0;
                    while (!done) begin
                        if (baud_tick) begin
                            t++;
                            if (b[1] && t == 16)
                                check(txd == 1'b0, "R3", "start bit still low at tick 16", txd, 0);
                            if (b[1] && t == 17)
                                check(txd == 1'b1, "R3", "first data bit after tick 16", txd, 1);
                            if (t >= 8 && ((t - 8) % 16) == 0) begin
                                k = (t - 8) / 16;
                                lbl = (k == sl) ? rq : ((k >= st) ? "R7" : "R2");
                                check(txd == b[k], lbl, $sformatf("frame bit %0d", k), txd, b[k]);
                                if (k == n - 1) done = 1;
                            end
                        end
                        if (!done) @(negedge clk);
                    end
                    mon_busy = 0;
                end
            end
            prev = txd;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog R2: got hung run expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(txd == 1'b1, "R1", "idle line", txd, 1);
        check(ovf_flag == 1'b0, "R1", "overflow flag", ovf_flag, 0);
        check(tx_irq == 1'b1, "R1", "interrupt at empty", tx_irq, 1);
        repeat (50) @(negedge clk);
        check(txd == 1'b1, "R1", "line stays idle", txd, 1);

        // R2 lengths, LSB first, upper bits dropped
        cur_req = "R2";
        send(8'hA5, 1'b0, "R2");
        send(8'h3C, 1'b1, "R2");
        drain();
        cfg_len = 2'd0;
        send(8'hF3, 1'b0, "R2");
        send(8'h0E, 1'b0, "R2");
        drain();
        cfg_len = 2'd1;
        send(8'hD9, 1'b0, "R2");
        drain();
        cfg_len = 2'd2;
        send(8'h6B, 1'b0, "R2");
        drain();

        // R4 even and odd parity, tag ignored (R6)
        cur_req = "R4";
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h07, 1'b1, "R4");
        send(8'h81, 1'b1, "R4");
        drain();
        cfg_par_odd = 1'b1;
        send(8'h07, 1'b0, "R4");
        send(8'h00, 1'b1, "R4");
        drain();
        cfg_len = 2'd2; cfg_par_odd = 1'b0;
        send(8'hC1, 1'b0, "R4");
        drain();

        // R5 stick parity
        cur_req = "R5";
        cfg_len = 2'd3; cfg_par_stick = 1'b1; cfg_par_odd = 1'b1;
        send(8'h00, 1'b0, "R5");
        send(8'hFF, 1'b0, "R5");
        drain();
        cfg_par_odd = 1'b0;
        send(8'hFF, 1'b1, "R5");
        drain();

        // R6 tag in the slot
        cur_req = "R6";
        cfg_nine = 1'b1; cfg_par_odd = 1'b1;
        send(8'h5A, 1'b0, "R6");
        send(8'h5A, 1'b1, "R6");
        drain();
        cfg_par_en = 1'b0; cfg_par_stick = 1'b0; cfg_par_odd = 1'b0;
        send(8'h12, 1'b1, "R6");
        drain();
        cfg_nine = 1'b0;

        // R7 two stop bits, back to back
        cur_req = "R7";
        cfg_stop2 = 1'b1;
        send(8'hFE, 1'b0, "R7");
        send(8'h01, 1'b0, "R7");
        drain();

        // R10 watermark with five waiting items
        cur_req = "R10";
        for (int i = 0; i < 6; i++)
            send(8'(8'h40 + i), 1'b0, "R10");
        cfg_lvl = 3'd0; #1;
        check(tx_irq == 1'b0, "R10", "level 0 with 5 waiting", tx_irq, 0);
        cfg_lvl = 3'd1; #1;
        check(tx_irq == 1'b0, "R10", "level 1 with 5 waiting", tx_irq, 0);
        cfg_lvl = 3'd2; #1;
        check(tx_irq == 1'b1, "R10", "level 2 with 5 waiting", tx_irq, 1);
        cfg_lvl = 3'd6; #1;
        check(tx_irq == 1'b0, "R10", "level 6 with 5 waiting", tx_irq, 0);
        cfg_lvl = 3'd0;
        drain();
        check(tx_irq == 1'b1, "R10", "level 0 after drain", tx_irq, 1);

        // R8 full queue and sticky overflow
        cur_req = "R8";
        cfg_stop2 = 1'b0; cfg_len = 2'd0;
        for (int i = 0; i < 33; i++)
            send(8'(i * 7 + 3), 1'b0, "R8");
        check(ovf_flag == 1'b0, "R8", "no overflow with 32 waiting", ovf_flag, 0);
        cfg_lvl = 3'd5; #1;
        check(tx_irq == 1'b0, "R10", "level 5 with 32 waiting", tx_irq, 0);
        cfg_lvl = 3'd3; #1;
        check(tx_irq == 1'b0, "R10", "level 3 with 32 waiting", tx_irq, 0);
        cfg_lvl = 3'd0;
        send_drop(8'h1F);
        check(ovf_flag == 1'b1, "R8", "overflow after write to full queue", ovf_flag, 1);
        drain();
        check(ovf_flag == 1'b1, "R8", "overflow stays set", ovf_flag, 1);

        // R9 single holding register
        cur_req = "R9";
        cfg_fifo_en = 1'b0; cfg_len = 2'd3;
        send(8'h11, 1'b0, "R9");
        repeat (3) @(negedge clk);
        send(8'h22, 1'b0, "R9");
        send_drop(8'h33);
        drain();
        check(txd == 1'b1, "R9", "idle after two frames", txd, 1);
        cfg_fifo_en = 1'b1;

        // R11 break after the current frame
        cur_req = "R11";
        brk_ok = 1;
        send(8'hC3, 1'b0, "R11");
        repeat (3) @(negedge clk);
        cfg_brk = 1'b1;
        while (q_bits.size() != 0 || mon_busy) @(negedge clk);
        repeat (100) @(negedge clk);
        check(txd == 1'b0, "R11", "line low during break", txd, 0);
        send(8'h96, 1'b0, "R11");
        repeat (1500) @(negedge clk);
        check(txd == 1'b0, "R11", "break holds queued item", txd, 0);
        check(q_bits.size() == 1, "R11", "queued item not sent", q_bits.size(), 1);
        cfg_brk = 1'b0;
        drain();
        brk_ok = 0;
        check(txd == 1'b1, "R11", "idle after break release", txd, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule